// File: doc/BRIEF.md
# Bunch-Crossing Event Memory with Serial Readout

This block keeps the results of an acquisition window so that they can be read out afterwards. For each bunch crossing, upstream logic presents a sample strobe, a bunch-crossing number and the processed results for that crossing. Depending on a 2-bit operating mode, the results are a 48-bit binary hit map, up to eight 7-bit centroids, or up to four 13-bit stubs. The block folds whichever set applies into one 72-bit word. It stores the word only when the crossing actually carries data. The store holds at most 96 words and never overwrites.

When the shutter goes low the acquisition ends. An external, slow readout clock then pulls the stored words out one bit at a time on its falling edges. The oldest word comes first and each word is sent from its top bit down. A word that has been sent is gone, and once the store is drained the serial line sits at 0. A single empty flag tells the outside world whether anything was captured. Opening the shutter again, or pulsing the clear input, wipes the store.

The readout clock is sampled in the system clock domain through a two-stage synchronizer. A falling edge therefore moves the serial output on the second system-clock edge after the readout clock drops.

Top module: `event_readout_mem`

## Requirements
- R1: The store holds 96 words of 72 bits. A crossing that arrives while 96 words are held is dropped, and the words already held are neither changed nor overwritten.
- R2: A rising edge of `shutter`, or a high `clear` sampled on a clock edge, empties the store and restarts readout. After that edge `mem_empty` is 1 and `mem_sdo` is 0.
- R3: A crossing is stored only if it carries data. In mode 2'b11 that means at least one hit bit is set. In mode 2'b10 the centroid count must be non-zero. In mode 2'b00 the stub count must be non-zero. Mode 2'b01 never stores anything.
- R4: In mode 2'b11 the word holds the hit map in bits 47:0, the bunch number in bits 63:48 and 8'hFF in bits 71:64.
- R5: In mode 2'b10, centroid k (k = 0..7) sits in bits 7k+6:7k, and the bunch number sits in bits 71:56. Slots at or above the centroid count read as zero.
- R6: In mode 2'b00, stub k (k = 0..3) sits in bits 13k+12:13k, the bunch number in bits 67:52 and 4'hF in bits 71:68. Slots at or above the stub count read as zero.
- R7: `mem_empty` is 1 while the store holds no word and goes to 0 in the cycle after the first word is written.
- R8: The readout advances only while `shutter` is 0, by one bit per falling edge of `ro_clk`. The first word stored is sent first, bit 71 first and bit 0 last. Readout clock edges while `shutter` is 1 have no effect.
- R9: Each stored word is sent exactly once. After the last bit of the last word, every further falling edge drives `mem_sdo` to 0.
- R10: Strobes while `shutter` is 0 store nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_mode | input | 2 | Operating mode: 00 stubs, 01 no storage, 10 centroids, 11 raw hits |
| evt_stb | input | 1 | One-cycle strobe marking a valid bunch crossing |
| hits | input | 48 | Binary hit map of the crossing |
| cents | input | 56 | Eight 7-bit centroids, slot 0 lowest |
| cent_cnt | input | 4 | Number of valid centroids (0..8) |
| stubs | input | 52 | Four 13-bit stubs, slot 0 lowest |
| stub_cnt | input | 3 | Number of valid stubs (0..4) |
| bx_id | input | 16 | Bunch-crossing number |
| clear | input | 1 | Synchronous wipe of the store |
| shutter | input | 1 | High during acquisition, low during readout |
| ro_clk | input | 1 | Readout clock; falling edges shift data out |
| mem_sdo | output | 1 | Serial memory data |
| mem_empty | output | 1 | High while no word is stored |

## Verification
The bench sends 100 data-carrying crossings into a 96-word store. A store that wrapped or overwrote would either replace the oldest words or return more than 96 words before the line goes quiet. Crossings with no data, and crossings in the no-storage mode, are mixed in; a wrong data test would add words to the readout stream. Partially filled centroid and stub crossings carry non-zero values in their unused slots, so a design that does not blank those slots returns wrong words. Readout clock edges during acquisition, strobes after the shutter closes, and a mid-acquisition clear each target a specific fault: premature shifting would lose the top bits of the first word, late writes would add words, and a missed clear would resurrect stale words.

// File: rtl/evmem_pkg.sv
package evmem_pkg;

    typedef enum logic [1:0] {
        MODE_STUB  = 2'b00,
        MODE_STRIP = 2'b01,
        MODE_CENT  = 2'b10,
        MODE_RAW   = 2'b11
    } op_mode_e;

    localparam int WORD_W     = 72;
    localparam int MEM_DEPTH  = 96;
    localparam int BX_W       = 16;
    localparam int HIT_W      = 48;
    localparam int CENT_W     = 7;
    localparam int N_CENT     = 8;
    localparam int STUB_W     = 13;
    localparam int N_STUB     = 4;
    localparam int RAW_HDR_W  = 8;
    localparam int STUB_HDR_W = 4;

endpackage

// File: rtl/evmem_packer.sv
module evmem_packer
    import evmem_pkg::*;
#(
    parameter int P_WORD_W     = WORD_W,
    parameter int P_BX_W       = BX_W,
    parameter int P_HIT_W      = HIT_W,
    parameter int P_CENT_W     = CENT_W,
    parameter int P_N_CENT     = N_CENT,
    parameter int P_STUB_W     = STUB_W,
    parameter int P_N_STUB     = N_STUB,
    parameter int P_RAW_HDR_W  = RAW_HDR_W,
    parameter int P_STUB_HDR_W = STUB_HDR_W,
    localparam int CCNT_W      = $clog2(P_N_CENT + 1),
    localparam int SCNT_W      = $clog2(P_N_STUB + 1),
    localparam int CENT_BITS   = P_N_CENT * P_CENT_W,
    localparam int STUB_BITS   = P_N_STUB * P_STUB_W
) (
    input  logic [1:0]            mode_i,
    input  logic [P_HIT_W-1:0]    hits_i,
    input  logic [CENT_BITS-1:0]  cents_i,
    input  logic [CCNT_W-1:0]     cent_cnt_i,
    input  logic [STUB_BITS-1:0]  stubs_i,
    input  logic [SCNT_W-1:0]     stub_cnt_i,
    input  logic [P_BX_W-1:0]     bx_i,
    output logic [P_WORD_W-1:0]   word_o,
    output logic                  has_data_o
);

    // Bit positions derived from the slot sizes
    localparam int RAW_BX_LSB  = P_HIT_W;
    localparam int STUB_BX_LSB = STUB_BITS;

    logic [CENT_BITS-1:0] cents_kept;
    logic [STUB_BITS-1:0] stubs_kept;

    // Blank every slot at or above the valid count
    for (genvar k = 0; k < P_N_CENT; k++) begin : g_cent_slot
        assign cents_kept[k*P_CENT_W +: P_CENT_W] =
            (CCNT_W'(k) < cent_cnt_i) ? cents_i[k*P_CENT_W +: P_CENT_W] : '0;
    end

    for (genvar k = 0; k < P_N_STUB; k++) begin : g_stub_slot
        assign stubs_kept[k*P_STUB_W +: P_STUB_W] =
            (SCNT_W'(k) < stub_cnt_i) ? stubs_i[k*P_STUB_W +: P_STUB_W] : '0;
    end

    always_comb begin
        word_o     = '0;
        has_data_o = 1'b0;
        unique case (op_mode_e'(mode_i))
            MODE_RAW: begin
                word_o[P_HIT_W-1:0]                    = hits_i;
                word_o[RAW_BX_LSB +: P_BX_W]           = bx_i;
                word_o[P_WORD_W-1 -: P_RAW_HDR_W]      = '1;
                has_data_o                             = |hits_i;
            end
            MODE_CENT: begin
                word_o[CENT_BITS-1:0]                  = cents_kept;
                word_o[P_WORD_W-1 -: P_BX_W]           = bx_i;
                has_data_o                             = (cent_cnt_i != '0);
            end
            MODE_STUB: begin
                word_o[STUB_BITS-1:0]                  = stubs_kept;
                word_o[STUB_BX_LSB +: P_BX_W]          = bx_i;
                word_o[P_WORD_W-1 -: P_STUB_HDR_W]     = '1;
                has_data_o                             = (stub_cnt_i != '0);
            end
            default: begin
                word_o     = '0;
                has_data_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/evmem_store.sv
module evmem_store
    import evmem_pkg::*;
#(
    parameter int P_WORD_W = WORD_W,
    parameter int P_DEPTH  = MEM_DEPTH,
    localparam int AW      = $clog2(P_DEPTH),
    localparam int CW      = $clog2(P_DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shutter_i,
    input  logic                 clear_i,
    input  logic                 evt_stb_i,
    input  logic                 has_data_i,
    input  logic [P_WORD_W-1:0]  word_i,
    input  logic [AW-1:0]        rd_addr_i,
    output logic [P_WORD_W-1:0]  rd_word_o,
    output logic [CW-1:0]        count_o,
    output logic                 empty_o,
    output logic                 flush_o
);

    typedef struct packed {
        logic          shut;
        logic [CW-1:0] count;
    } store_st_t;

    store_st_t st_d, st_q;
    logic      flush;
    logic      wr_en;
    logic [P_WORD_W-1:0] mem_q [P_DEPTH];

    always_comb begin
        st_d      = st_q;
        st_d.shut = shutter_i;
        flush     = clear_i | (shutter_i & ~st_q.shut);
        wr_en     = ~flush & shutter_i & evt_stb_i & has_data_i
                    & (st_q.count != CW'(P_DEPTH));
        if (flush) begin
            st_d.count = '0;
        end else if (wr_en) begin
            st_d.count = st_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[st_q.count[AW-1:0]] <= word_i;
        end
    end

    assign rd_word_o = mem_q[rd_addr_i];
    assign count_o   = st_q.count;
    assign empty_o   = (st_q.count == '0);
    assign flush_o   = flush;

    // R1: a full store keeps its fill level until flushed
    p_full_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.count == CW'(P_DEPTH)) && !flush |=> (st_q.count == CW'(P_DEPTH)));

    // R2: flush leaves the store empty
    p_flush_empties_r2: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty_o);

    // R7: fill level moves by at most one word per cycle outside a flush
    p_step_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> (st_q.count == $past(st_q.count))
                   || (st_q.count == $past(st_q.count) + 1'b1));

    // R10: no writes while the shutter is low
    p_idle_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !shutter_i && !flush |=> $stable(st_q.count));

endmodule

// File: rtl/evmem_reader.sv
module evmem_reader
    import evmem_pkg::*;
#(
    parameter int P_WORD_W = WORD_W,
    parameter int P_DEPTH  = MEM_DEPTH,
    localparam int AW      = $clog2(P_DEPTH),
    localparam int CW      = $clog2(P_DEPTH + 1),
    localparam int BW      = $clog2(P_WORD_W)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ro_clk_i,
    input  logic                 shutter_i,
    input  logic                 flush_i,
    input  logic [CW-1:0]        count_i,
    output logic [AW-1:0]        rd_addr_o,
    input  logic [P_WORD_W-1:0]  rd_word_i,
    output logic                 sdata_o
);

    typedef struct packed {
        logic                sync1;
        logic                sync2;
        logic [CW-1:0]       rd_ptr;
        logic [BW-1:0]       bits_left;
        logic [P_WORD_W-1:0] shreg;
        logic                sout;
    } rd_st_t;

    rd_st_t st_d, st_q;
    logic   ro_fall;

    always_comb begin
        st_d       = st_q;
        st_d.sync1 = ro_clk_i;
        st_d.sync2 = st_q.sync1;
        ro_fall    = st_q.sync2 & ~st_q.sync1;
        if (flush_i) begin
            st_d.rd_ptr    = '0;
            st_d.bits_left = '0;
            st_d.shreg     = '0;
            st_d.sout      = 1'b0;
        end else if (ro_fall && !shutter_i) begin
            if (st_q.bits_left != '0) begin
                st_d.sout      = st_q.shreg[P_WORD_W-1];
                st_d.shreg     = st_q.shreg << 1;
                st_d.bits_left = st_q.bits_left - 1'b1;
            end else if (st_q.rd_ptr < count_i) begin
                st_d.sout      = rd_word_i[P_WORD_W-1];
                st_d.shreg     = rd_word_i << 1;
                st_d.bits_left = BW'(P_WORD_W - 1);
                st_d.rd_ptr    = st_q.rd_ptr + 1'b1;
            end else begin
                st_d.sout      = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_addr_o = st_q.rd_ptr[AW-1:0];
    assign sdata_o   = st_q.sout;

    // R8: the serial line does not move during acquisition
    p_quiet_in_acq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        shutter_i && !flush_i |=> $stable(sdata_o));

    // R9: read pointer never moves back except on flush
    p_read_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_i |=> st_q.rd_ptr >= $past(st_q.rd_ptr));

    // R9: never read past the stored words
    p_ptr_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rd_ptr <= count_i);

    // R9: drained store gives zeros
    p_drained_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_i && !shutter_i && ro_fall && (st_q.rd_ptr == count_i)
        && (st_q.bits_left == '0) |=> !sdata_o);

endmodule

// File: rtl/event_readout_mem.sv
module event_readout_mem
    import evmem_pkg::*;
#(
    parameter int P_WORD_W = WORD_W,
    parameter int P_DEPTH  = MEM_DEPTH,
    parameter int P_BX_W   = BX_W,
    parameter int P_HIT_W  = HIT_W,
    parameter int P_CENT_W = CENT_W,
    parameter int P_N_CENT = N_CENT,
    parameter int P_STUB_W = STUB_W,
    parameter int P_N_STUB = N_STUB,
    localparam int CCNT_W  = $clog2(P_N_CENT + 1),
    localparam int SCNT_W  = $clog2(P_N_STUB + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0]                   op_mode,
    input  logic                         evt_stb,
    input  logic [P_HIT_W-1:0]           hits,
    input  logic [P_N_CENT*P_CENT_W-1:0] cents,
    input  logic [CCNT_W-1:0]            cent_cnt,
    input  logic [P_N_STUB*P_STUB_W-1:0] stubs,
    input  logic [SCNT_W-1:0]            stub_cnt,
    input  logic [P_BX_W-1:0]            bx_id,
    input  logic                         clear,
    input  logic                         shutter,
    input  logic                         ro_clk,
    output logic                         mem_sdo,
    output logic                         mem_empty
);

    localparam int AW = $clog2(P_DEPTH);
    localparam int CW = $clog2(P_DEPTH + 1);

    logic [P_WORD_W-1:0] packed_word;
    logic                has_data;
    logic [P_WORD_W-1:0] rd_word;
    logic [AW-1:0]       rd_addr;
    logic [CW-1:0]       fill;
    logic                flush;

    evmem_packer #(
        .P_WORD_W (P_WORD_W),
        .P_BX_W   (P_BX_W),
        .P_HIT_W  (P_HIT_W),
        .P_CENT_W (P_CENT_W),
        .P_N_CENT (P_N_CENT),
        .P_STUB_W (P_STUB_W),
        .P_N_STUB (P_N_STUB)
    ) u_packer (
        .mode_i     (op_mode),
        .hits_i     (hits),
        .cents_i    (cents),
        .cent_cnt_i (cent_cnt),
        .stubs_i    (stubs),
        .stub_cnt_i (stub_cnt),
        .bx_i       (bx_id),
        .word_o     (packed_word),
        .has_data_o (has_data)
    );

    evmem_store #(
        .P_WORD_W (P_WORD_W),
        .P_DEPTH  (P_DEPTH)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .shutter_i  (shutter),
        .clear_i    (clear),
        .evt_stb_i  (evt_stb),
        .has_data_i (has_data),
        .word_i     (packed_word),
        .rd_addr_i  (rd_addr),
        .rd_word_o  (rd_word),
        .count_o    (fill),
        .empty_o    (mem_empty),
        .flush_o    (flush)
    );

    evmem_reader #(
        .P_WORD_W (P_WORD_W),
        .P_DEPTH  (P_DEPTH)
    ) u_reader (
        .clk       (clk),
        .rst_n     (rst_n),
        .ro_clk_i  (ro_clk),
        .shutter_i (shutter),
        .flush_i   (flush),
        .count_i   (fill),
        .rd_addr_o (rd_addr),
        .rd_word_i (rd_word),
        .sdata_o   (mem_sdo)
    );

endmodule

// File: tb/event_readout_mem_tb.sv
module event_readout_mem_tb;

    typedef struct {
        logic [71:0] word;
        string       tag;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_mode = 2'b00;
    logic        evt_stb = 1'b0;
    logic [47:0] hits = '0;
    logic [55:0] cents = '0;
    logic [3:0]  cent_cnt = '0;
    logic [51:0] stubs = '0;
    logic [2:0]  stub_cnt = '0;
    logic [15:0] bx_id = '0;
    logic        clear = 1'b0;
    logic        shutter = 1'b0;
    logic        ro_clk = 1'b1;
    logic        mem_sdo;
    logic        mem_empty;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;
    int stored = 0;
    exp_item_t exp_q[$];

    always #10 clk = ~clk;

    event_readout_mem u_dut (
        .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .evt_stb(evt_stb),
        .hits(hits), .cents(cents), .cent_cnt(cent_cnt), .stubs(stubs),
        .stub_cnt(stub_cnt), .bx_id(bx_id), .clear(clear), .shutter(shutter),
        .ro_clk(ro_clk), .mem_sdo(mem_sdo), .mem_empty(mem_empty)
    );

    task automatic check(input bit ok, input string req,
                         input logic [71:0] act, input logic [71:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected word and data flag, built from the layout requirements
    function automatic logic [72:0] model(input logic [1:0] m, input logic [47:0] h,
            input logic [55:0] c, input logic [3:0] cc, input logic [51:0] s,
            input logic [2:0] sc, input logic [15:0] bx);
        logic [71:0] w = '0;
        logic        has = 1'b0;
        case (m)
            2'b11: begin
                w[47:0] = h; w[63:48] = bx; w[71:64] = 8'hFF; has = |h;
            end
            2'b10: begin
                for (int k = 0; k < 8; k++)
                    if (k < int'(cc)) w[k*7 +: 7] = c[k*7 +: 7];
                w[71:56] = bx; has = (cc != 0);
            end
            2'b00: begin
                for (int k = 0; k < 4; k++)
                    if (k < int'(sc)) w[k*13 +: 13] = s[k*13 +: 13];
                w[67:52] = bx; w[71:68] = 4'hF; has = (sc != 0);
            end
            default: has = 1'b0;
        endcase
        return {has, w};
    endfunction

    // Driver: one strobe, expectation pushed into the scoreboard
    task automatic send(input logic [1:0] m, input logic [47:0] h,
            input logic [55:0] c, input logic [3:0] cc, input logic [51:0] s,
            input logic [2:0] sc, input logic [15:0] bx, input string tag);
        logic [72:0] r;
        exp_item_t   it;
        r = model(m, h, c, cc, s, sc, bx);
        @(negedge clk);
        op_mode = m; hits = h; cents = c; cent_cnt = cc;
        stubs = s; stub_cnt = sc; bx_id = bx; evt_stb = 1'b1;
        @(negedge clk);
        evt_stb = 1'b0;
        if (r[72] && shutter && stored < 96) begin
            it.word = r[71:0];
            it.tag  = tag;
            exp_q.push_back(it);
            stored++;
        end
    endtask

    task automatic ro_pulse(output logic bit_o);
        ro_clk = 1'b0;
        repeat (4) @(negedge clk);
        bit_o = mem_sdo;
        ro_clk = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic read_word(output logic [71:0] w);
        for (int i = 71; i >= 0; i--) begin
            logic b;
            ro_pulse(b);
            w[i] = b;
        end
    endtask

    // Monitor: pop and compare every expected word, then expect silence
    task automatic drain();
        logic [71:0] got;
        exp_item_t   it;
        while (exp_q.size() > 0) begin
            read_word(got);
            it = exp_q.pop_front();
            check(got === it.word, {it.tag, "/R8"}, got, it.word);
        end
        read_word(got);
        check(got === 72'h0, "R9 drained line stays 0", got, 72'h0);
    endtask

    task automatic set_shutter(input logic v);
        @(negedge clk);
        shutter = v;
        if (v) begin
            exp_q.delete();
            stored = 0;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_empty === 1'b1, "R2 reset empty", 72'(mem_empty), 72'h1);
        check(mem_sdo === 1'b0, "R2 reset sdo", 72'(mem_sdo), 72'h0);

        // Acquisition 1: all layouts, data filtering
        set_shutter(1'b1);
        check(mem_empty === 1'b1, "R2 open empty", 72'(mem_empty), 72'h1);
        send(2'b11, 48'h0, '0, 0, '0, 0, 16'h1111, "R3");
        send(2'b01, 48'hFFFF, {8{7'h55}}, 8, {4{13'h1ABC}}, 4, 16'h2222, "R3");
        send(2'b10, 48'h0, {8{7'h7F}}, 0, '0, 0, 16'h3333, "R3");
        send(2'b00, 48'h0, '0, 0, {4{13'h1FFF}}, 0, 16'h4444, "R3");
        check(mem_empty === 1'b1, "R3 no-data crossings not stored",
              72'(mem_empty), 72'h1);
        send(2'b11, 48'h8000_0000_0001, '0, 0, '0, 0, 16'hBEEF, "R4");
        check(mem_empty === 1'b0, "R7 empty falls", 72'(mem_empty), 72'h0);
        send(2'b10, '0, {7'h11,7'h22,7'h33,7'h44,7'h55,7'h66,7'h77,7'h0F},
             3, '0, 0, 16'hCAFE, "R5");
        send(2'b10, '0, {7'h01,7'h02,7'h03,7'h04,7'h05,7'h06,7'h07,7'h08},
             8, '0, 0, 16'h0102, "R5");
        send(2'b00, '0, '0, 0, {13'h1111,13'h0AAA,13'h1555,13'h0123},
             2, 16'hD00D, "R6");
        send(2'b00, '0, '0, 0, {13'h1FFE,13'h0001,13'h1000,13'h0777},
             4, 16'h7007, "R6");
        // Readout clock activity during acquisition must be ignored
        for (int i = 0; i < 5; i++) begin
            logic b;
            ro_pulse(b);
            check(b === 1'b0, "R8 no shift while shutter high", 72'(b), 72'h0);
        end
        set_shutter(1'b0);
        send(2'b11, 48'hFFFF_FFFF_FFFF, '0, 0, '0, 0, 16'h9999, "R10");
        drain();

        // Acquisition 2: overflow
        set_shutter(1'b1);
        check(mem_empty === 1'b1, "R2 reopen empties", 72'(mem_empty), 72'h1);
        for (int i = 0; i < 100; i++)
            send(2'b11, 48'(i + 1), '0, 0, '0, 0, 16'(i), "R1");
        set_shutter(1'b0);
        drain();

        // Acquisition 3: clear during acquisition
        set_shutter(1'b1);
        send(2'b11, 48'h5, '0, 0, '0, 0, 16'hAAAA, "R2");
        send(2'b00, '0, '0, 0, {4{13'h0F0F}}, 1, 16'hBBBB, "R2");
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        exp_q.delete();
        stored = 0;
        check(mem_empty === 1'b1, "R2 clear empties", 72'(mem_empty), 72'h1);
        send(2'b10, '0, {8{7'h2A}}, 1, '0, 0, 16'hCCCC, "R5");
        set_shutter(1'b0);
        drain();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule